// File: doc/BRIEF.md
# Two-Channel Converter Serial Port Slave

This block is the digital half of a two-channel successive-approximation converter's serial port. The host frames each transfer with an active-low chip select and clocks it with a serial clock. Both pins are sampled by the block's fabric clock, and all edges are found by comparing each sample with the one before. A falling chip select samples the selected input, which pulses a strobe with the channel number to a parallel code source. It then builds a 16-bit result word and starts driving the serial output. Later serial-clock falling edges shift the word out, MSB first, and pick up the channel choice for the next conversion from the serial input.

The block also follows the operating mode from where the chip-select rising edge falls in the count of serial-clock falling edges. It can drop into power-down, and a dummy frame brings it back. The output enable and the serial data bit are separate ports. Together they stand for a three-state pin: the data bit reads 0 whenever the enable is low. The parameter `RES_BITS` picks a 12-bit or 10-bit result.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, `dout_oe` is 0, `pwr_state` is 0 (normal), `track` is 1, `data_valid` is 0 and channel 0 is selected.
- R2: A chip-select falling edge raises `sample_stb` for exactly one cycle, with `sample_ch` set to the channel being converted. In the same update it sets `dout_oe` to 1 with `dout` at 0, and drops `track` to 0.
- R3: The word is sent MSB first. Bits 15 and 14 are 0, bit 13 is the channel ID, bit 12 is 0, and bits 11..0 are the code. With `RES_BITS`=10, bits 11..2 hold the code and bits 1..0 are 0.
- R4: Bit 15 appears at the chip-select fall, and bit 15-k appears after the k-th counted serial-clock fall. `dout_oe` returns to 0 on the 16th fall.
- R5: A chip-select rise before the frame is complete clears `dout_oe` at once, and the channel picked up in that frame is not committed.
- R6: Only the serial-input bit taken on the 3rd serial-clock fall is used (1 = channel 1, 0 = channel 0). It becomes the active channel when the frame completes. All other serial-input bits have no effect.
- R7: The ID bit and `sample_ch` show the channel committed by the previous completed frame.
- R8: In normal mode, a chip-select rise after 2 to 9 falls gives `pwr_state`=1 (down). A rise after fewer than 2 falls, or after 10 or more, leaves it at 0.
- R9: In power-down, a chip-select fall gives `pwr_state`=2 (waking), and that frame has `data_valid`=0. The 10th fall of that frame gives 0. A chip-select rise before the 10th fall gives 1 again.
- R10: `track` returns to 1 on the serial-clock rise that follows the 13th fall.
- R11: A serial-clock fall seen in the same sample as the chip-select fall is not counted.
- R12: With `RES_BITS`=10, a chip-select rise after 14 or more falls counts as a completed frame and commits the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (frame) |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial input carrying the channel choice |
| code_ch0 | input | RES_BITS | Conversion code for channel 0 |
| code_ch1 | input | RES_BITS | Conversion code for channel 1 |
| sample_stb | output | 1 | One-cycle pulse at the sampling instant |
| sample_ch | output | 1 | Channel sampled at the last strobe |
| dout | output | 1 | Serial result bit, 0 when not enabled |
| dout_oe | output | 1 | Serial output enable; low means high impedance |
| pwr_state | output | 2 | 0 normal, 1 down, 2 waking |
| data_valid | output | 1 | The current frame carries a valid result |
| track | output | 1 | 1 while the input is tracked, 0 while held |

## Verification
The chip-select fall that opens a frame and a serial-clock fall can arrive in the same fabric sample. If the block counted that edge, the word would be cut short by one bit. The bench drives both pins low at one negative clock edge. It then checks that `dout_oe` is still high after 15 further falls, drops only on the 16th, and that all 16 captured bits equal the word expected for the codes applied.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

  typedef logic [4:0] cnt_t;

  localparam cnt_t FALLS_FRAME = 5'd16;
  localparam cnt_t FALLS_SHORT = 5'd14;
  localparam cnt_t FALL_DIN    = 5'd3;
  localparam cnt_t FALL_PD_LO  = 5'd2;
  localparam cnt_t FALL_WAKE   = 5'd10;
  localparam cnt_t FALL_TRACK  = 5'd13;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'd0,
    PWR_DOWN   = 2'd1,
    PWR_WAKE   = 2'd2
  } pwr_e;

  // Result word: two zeros, ID, zero, then the code (short codes padded below).
  function automatic logic [15:0] make_frame(input logic id, input logic [11:0] code,
                                             input logic short_res);
    if (short_res) return {2'b00, id, 1'b0, code[9:0], 2'b00};
    return {2'b00, id, 1'b0, code};
  endfunction

  // Rise in this window of fall counts sends a powered device down.
  function automatic logic in_pd_window(input cnt_t n);
    return (n >= FALL_PD_LO) && (n < FALL_WAKE);
  endfunction

endpackage

// File: rtl/adc_pin_edge.sv
module adc_pin_edge #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= INIT;
    else        pin_q <= pin;
  end

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_serial_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic wake_ev,
  input  logic early_rise,
  input  cnt_t cnt,
  output pwr_e state
);
  pwr_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      PWR_NORMAL: if (early_rise && in_pd_window(cnt)) state_nxt = PWR_DOWN;
      PWR_DOWN:   if (start_ev) state_nxt = PWR_WAKE;
      PWR_WAKE: begin
        if (wake_ev)         state_nxt = PWR_NORMAL;
        else if (early_rise) state_nxt = PWR_DOWN;
      end
      default:    state_nxt = PWR_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_NORMAL;
    else        state <= state_nxt;
  end

  assert_down_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_DOWN && !start_ev) |=> state == PWR_DOWN);
  assert_wake_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == PWR_WAKE) |-> $past(state) == PWR_DOWN);
  assert_no_early_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_NORMAL && early_rise && cnt < FALL_PD_LO) |=> state == PWR_NORMAL);
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WORD-1:0] word,
  input  logic            shift,
  input  logic            stop,
  output logic            dout,
  output logic            dout_oe
);
  logic [WORD-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      dout_oe <= 1'b0;
    end else if (load) begin
      sr      <= word;
      dout_oe <= 1'b1;
    end else begin
      if (shift) sr <= {sr[WORD-2:0], 1'b0};
      if (stop)  dout_oe <= 1'b0;
    end
  end

  assign dout = dout_oe & sr[WORD-1];

  assert_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);
  assert_quiet_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_serial_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                din,
  input  logic [RES_BITS-1:0] code_ch0,
  input  logic [RES_BITS-1:0] code_ch1,
  output logic                sample_stb,
  output logic                sample_ch,
  output logic                dout,
  output logic                dout_oe,
  output logic [1:0]          pwr_state,
  output logic                data_valid,
  output logic                track
);
  localparam logic SHORT_RES = (RES_BITS != 12);

  // Named internal events
  logic cs_rise, cs_fall, sclk_rise_raw, sclk_fall_raw;
  logic fall_ev, frame_done_ev, early_rise, short_done, abort_ev, commit_ev;
  logic din_ev, wake_ev, track_ev;

  logic  active, next_ch, cur_ch;
  cnt_t  cnt, cnt_nxt;
  pwr_e  pstate;
  logic [11:0] code12;
  logic [RES_BITS-1:0] sel_code;

  adc_pin_edge #(.INIT(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .pin(cs_n), .rise(cs_rise), .fall(cs_fall));
  adc_pin_edge #(.INIT(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .pin(sclk), .rise(sclk_rise_raw), .fall(sclk_fall_raw));

  assign cnt_nxt       = cnt + 5'd1;
  assign fall_ev       = sclk_fall_raw & ~cs_n & active;
  assign frame_done_ev = fall_ev && (cnt_nxt == FALLS_FRAME);
  assign early_rise    = cs_rise & active;
  assign short_done    = early_rise & SHORT_RES & (cnt >= FALLS_SHORT);
  assign abort_ev      = early_rise & ~short_done;
  assign commit_ev     = frame_done_ev | short_done;
  assign din_ev        = fall_ev && (cnt_nxt == FALL_DIN);
  assign wake_ev       = fall_ev && (cnt_nxt == FALL_WAKE);
  assign track_ev      = sclk_rise_raw & active & (cnt == FALL_TRACK);

  assign sel_code = cur_ch ? code_ch1 : code_ch0;

  generate
    if (RES_BITS == 12) begin : g_full
      assign code12 = sel_code;
    end else begin : g_short
      assign code12 = {{(12-RES_BITS){1'b0}}, sel_code};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      next_ch    <= 1'b0;
      cur_ch     <= 1'b0;
      data_valid <= 1'b0;
      track      <= 1'b1;
      sample_stb <= 1'b0;
      sample_ch  <= 1'b0;
    end else begin
      sample_stb <= cs_fall;
      if (cs_fall) begin
        active     <= 1'b1;
        cnt        <= '0;
        track      <= 1'b0;
        sample_ch  <= cur_ch;
        data_valid <= (pstate == PWR_NORMAL);
      end else begin
        if (fall_ev) cnt <= cnt_nxt;
        if (frame_done_ev || early_rise) begin
          active     <= 1'b0;
          data_valid <= 1'b0;
        end
        if (track_ev || early_rise) track <= 1'b1;
      end
      if (din_ev)    next_ch <= din;
      if (commit_ev) cur_ch  <= next_ch;
    end
  end

  adc_pwr_ctrl u_pwr (
    .clk(clk), .rst_n(rst_n), .start_ev(cs_fall), .wake_ev(wake_ev),
    .early_rise(early_rise), .cnt(cnt), .state(pstate));

  assign pwr_state = pstate;

  adc_frame_shift #(.WORD(16)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(cs_fall),
    .word(make_frame(cur_ch, code12, SHORT_RES)),
    .shift(fall_ev), .stop(frame_done_ev | early_rise),
    .dout(dout), .dout_oe(dout_oe));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FALLS_FRAME);
  assert_oe_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> $past(frame_done_ev || early_rise));
  assert_abort_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !dout_oe);
  assert_id_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(cur_ch));
  assert_stb_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
  assert_valid_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(pstate) == PWR_NORMAL);
  assert_track_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |-> $past(track_ev || early_rise));
  assert_first_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> cnt == 5'd0);
endmodule

// File: tb/adc_serial_slave_bench.sv
module adc_serial_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [11:0] code0 = '0, code1 = '0;
  logic dout, oe, stb, sch, dv, trk;
  logic [1:0] ps;
  logic dout10, oe10, stb10, sch10, dv10, trk10;
  logic [1:0] ps10;
  logic [15:0] w12, w10;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_serial_slave #(.RES_BITS(12)) u_adc_serial_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .code_ch0(code0), .code_ch1(code1), .sample_stb(stb), .sample_ch(sch),
    .dout(dout), .dout_oe(oe), .pwr_state(ps), .data_valid(dv), .track(trk));

  adc_serial_slave #(.RES_BITS(10)) u_adc_serial_slave_w10 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .code_ch0(code0[9:0]), .code_ch1(code1[9:0]), .sample_stb(stb10), .sample_ch(sch10),
    .dout(dout10), .dout_oe(oe10), .pwr_state(ps10), .data_valid(dv10), .track(trk10));

  // {code0, code1, din word, expected 12-bit word}
  localparam logic [55:0] VEC [5] = '{
    {12'hA5C, 12'h3F1, 16'h0000, 16'h0A5C},
    {12'h123, 12'hABC, 16'h2000, 16'h0123},
    {12'hFFF, 12'h800, 16'hDFFF, 16'h2800},
    {12'h001, 12'h7E7, 16'h2000, 16'h0001},
    {12'h000, 12'hFFF, 16'h0000, 16'h2FFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_frame();
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    w12 = '0; w10 = '0;
    w12[15] = dout; w10[15] = dout10;
  endtask

  task automatic close_frame();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_falls(input logic [15:0] dw, input int first, input int last);
    for (int k = first; k <= last; k++) begin
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) begin sclk = 1'b0; din = dw[16-k]; end
      @(negedge clk);
      if (k <= 15) begin
        w12[15-k] = dout;
        w10[15-k] = dout10;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] e10;
    logic [11:0] sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", oe, 0);
    chk("R1 pwr", ps, 0);
    chk("R1 track", trk, 1);
    chk("R1 valid", dv, 0);
    chk("R1 strobe", stb, 0);

    // Vector walk: R3 R4 R6 R7
    foreach (VEC[i]) begin
      code0 = VEC[i][55:44];
      code1 = VEC[i][43:32];
      open_frame();
      run_falls(VEC[i][31:16], 1, 16);
      chk("R4 oe off at 16th fall", oe, 0);
      chk("R3/R6/R7 word 12-bit", w12, VEC[i][15:0]);
      sc  = VEC[i][13] ? code1 : code0;
      e10 = {2'b00, VEC[i][13], 1'b0, sc[9:0], 2'b00};
      chk("R3 word 10-bit", w10, e10);
      close_frame();
    end

    code0 = 12'h5A3; code1 = 12'hC3C;
    // R2 strobe
    open_frame();
    chk("R2 strobe", stb, 1);
    chk("R2 sample_ch", sch, 0);
    chk("R2 oe", oe, 1);
    chk("R2 first bit", dout, 0);
    chk("R2 hold", trk, 0);
    @(negedge clk);
    chk("R2 strobe one cycle", stb, 0);
    run_falls(16'h0000, 1, 16);
    close_frame();

    // R10 track return
    open_frame();
    run_falls(16'h0000, 1, 13);
    chk("R10 held after 13th fall", trk, 0);
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    chk("R10 track after rise", trk, 1);
    run_falls(16'h0000, 14, 16);
    close_frame();

    // R8 rise before 2nd fall stays normal
    open_frame();
    run_falls(16'h0000, 1, 1);
    close_frame();
    chk("R8 stay normal", ps, 0);

    // R5/R8 abort after 5 falls -> down; channel 1 request dropped
    open_frame();
    run_falls(16'h2000, 1, 5);
    close_frame();
    chk("R5 oe off on abort", oe, 0);
    chk("R8 down", ps, 1);

    // R9 failed wake
    open_frame();
    chk("R9 waking", ps, 2);
    chk("R9 dummy invalid", dv, 0);
    run_falls(16'h0000, 1, 7);
    close_frame();
    chk("R9 back down", ps, 1);

    // R9 successful wake
    open_frame();
    run_falls(16'h0000, 1, 9);
    chk("R9 still waking", ps, 2);
    run_falls(16'h0000, 10, 10);
    chk("R9 powered at 10th", ps, 0);
    chk("R9 dummy still invalid", dv, 0);
    run_falls(16'h0000, 11, 16);
    chk("R5 aborted channel not committed", w12[13], 0);
    close_frame();
    open_frame();
    chk("R9 next frame valid", dv, 1);
    run_falls(16'h0000, 1, 16);
    close_frame();

    // R8 rise after 12 falls stays normal
    open_frame();
    run_falls(16'h0000, 1, 12);
    close_frame();
    chk("R8 late rise normal", ps, 0);
    chk("R5 late abort oe", oe, 0);

    // R11 coincident edges
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    @(negedge clk) begin cs_n = 1'b0; sclk = 1'b0; end
    @(negedge clk);
    chk("R11 oe on", oe, 1);
    w12 = '0; w12[15] = dout;
    run_falls(16'h0000, 1, 15);
    chk("R11 oe after 15 falls", oe, 1);
    run_falls(16'h0000, 16, 16);
    chk("R11 oe after 16 falls", oe, 0);
    chk("R11 word", w12, 16'h05A3);
    close_frame();

    // R12 short-result completion at 14 falls
    open_frame();
    run_falls(16'h2000, 1, 14);
    close_frame();
    chk("R12 stays normal", ps10, 0);
    open_frame();
    run_falls(16'h0000, 1, 16);
    chk("R12 10-bit committed ch1", w10[13], 1);
    chk("R5 12-bit not committed", w12[13], 0);
    chk("R12 10-bit sample_ch", sch10, 1);
    close_frame();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule